// File: doc/BRIEF.md
# Resistive Touch Digitiser I2C Target

This block is the serial front of a four-wire resistive touch-screen digitiser. It watches the SCL and SDA lines of an open-drain I2C bus from the system clock domain. Both lines pass through a synchroniser and a glitch filter, and the block then detects START, repeated START and STOP conditions together with the SCL edges. A host first writes one command byte. That byte selects whether a measurement is wanted, which panel channel to drive, the pen-interrupt/power-down setting and the output resolution. The host then reads the result. When the address phase of a read completes, the block asks the converter for a sample and serialises the answer MSB first. The answer is one byte in 8-bit mode. In full-resolution mode it is a high byte followed by a low nibble that is padded with zeros.

A host that acknowledges the final byte of a result, instead of refusing it, gets a fresh conversion on the same channel, and the block streams that result straight away. The analog switches and the successive-approximation converter sit outside the block. They are reached through a request/done handshake that carries the result word.

Top module: `tsc_i2c_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 1001000 with bit 1 replaced by the strap input `strap_a0_i`. Bit 0 of that byte selects read (1) or write (0).
- R2: An address byte that does not match receives no ACK. Every following byte up to the next START or STOP also receives no ACK and leaves the command outputs unchanged.
- R3: In a write, the block acknowledges the byte after the address and latches its fields. Bit 7 is the measurement-select flag (0 = sleep), bits 6..4 are the channel, bit 2 is pen/power-down and bit 1 is resolution (1 = 8-bit). Bits 3 and 0 are ignored.
- R4: In 12-bit mode a read returns result bits 11..4 first, then a byte that holds result bits 3..0 in its upper nibble and zeros in its lower nibble.
- R5: In 8-bit mode a read returns a single byte that holds result bits 11..4, and a master NACK ends the data phase.
- R6: A master ACK on the last byte of a result starts a new conversion on the same channel, and the new result follows at once in the same format.
- R7: A repeated START ends a write and begins a new address phase without a STOP. A STOP releases SDA and returns the block to idle.
- R8: `conv_req_o` rises when a read address is accepted while a measurement command is latched. It stays high until `conv_done_i`, when the block captures `conv_data_i`, and it falls on the next cycle.
- R9: A read that arrives before any command, or after a sleep command, returns all-zero bytes and raises no conversion request.
- R10: SDA is driven only as an active-low enable that changes while SCL is low. A pulse on SCL shorter than `FILT_LEN` system clocks is ignored.
- R11: After reset, SDA is released, no conversion is requested and all command outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low |
| strap_a0_i | input | 1 | Board strap giving the address LSB |
| cmd_meas_o | output | 1 | Latched measurement-select flag |
| cmd_chan_o | output | 3 | Latched channel select |
| cmd_pd_o | output | 1 | Latched pen/power-down bit |
| cmd_res8_o | output | 1 | Latched 8-bit resolution select |
| conv_req_o | output | 1 | Conversion request to the converter |
| conv_done_i | input | 1 | Converter finished; data valid this cycle |
| conv_data_i | input | RES_W | Conversion result |

## Verification
The bench builds the block with two synchroniser stages, a three-clock glitch filter and a 12-bit result. The bus runs with a quarter period of 32 system clocks, which is close to 400 kHz at a 50 MHz clock. Under these settings a one-clock SCL dip falls below the filter length, so the bench can show that a corrupted bit count would lose the ACK. Both strap levels are exercised. The converter model answers within a few clocks, so a result is captured before the first data bit is driven. Changing the model's value between bytes lets a streamed second conversion be told apart from the first.

// File: rtl/tsc_i2c_pkg.sv
package tsc_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_TX_LOAD
   } tsc_state_e;

   typedef struct packed {
      logic       meas;
      logic [2:0] chan;
      logic       pd;
      logic       res8;
   } tsc_cmd_t;

endpackage

// File: rtl/tsc_line_filter.sv
module tsc_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tsc_line_filter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN <= 1) begin : g_nofilt
         assign filt_o = synced;
      end else begin : g_filt
         localparam int CW = $clog2(FILT_LEN);
         logic [CW-1:0] cnt_q;
         logic          lvl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               lvl_q <= 1'b1;
            end else if (synced == lvl_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
               cnt_q <= '0;
               lvl_q <= synced;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign filt_o = lvl_q;
      end
   endgenerate

endmodule

// File: rtl/tsc_bus_events.sv
module tsc_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_d;
   assign scl_fall  = ~scl_f & scl_d;
   assign start_det = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;

endmodule

// File: rtl/tsc_i2c_target.sv
module tsc_i2c_target
   import tsc_i2c_pkg::*;
#(
   parameter logic [5:0] ADDR_FIXED  = 6'b100100,
   parameter int         RES_W       = 12,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_o,
   input  logic             strap_a0_i,
   output logic             cmd_meas_o,
   output logic [2:0]       cmd_chan_o,
   output logic             cmd_pd_o,
   output logic             cmd_res8_o,
   output logic             conv_req_o,
   input  logic             conv_done_i,
   input  logic [RES_W-1:0] conv_data_i
);

   localparam int PAD_W = 16 - RES_W;

   generate
      if (RES_W < 9 || RES_W > 15) begin : g_bad_res
         $error("tsc_i2c_target: RES_W must lie in 9..15");
      end
   endgenerate

   // line conditioning, one instance per bus wire
   logic [1:0] raw_l, filt_l;
   logic       scl_f, sda_f;
   assign raw_l = {sda_i, scl_i};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_line
         tsc_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
         ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_l[g]),
            .filt_o(filt_l[g])
         );
      end
   endgenerate
   assign scl_f = filt_l[0];
   assign sda_f = filt_l[1];

   logic scl_rise, scl_fall, start_det, stop_det;

   tsc_bus_events u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (scl_f),
      .sda_f    (sda_f),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   tsc_state_e       state_q;
   logic [2:0]       bit_q;
   logic [7:0]       sh_q;
   logic             rw_q, ack_q, byte_q, seen_q, req_q;
   tsc_cmd_t         cmd_q;
   logic [RES_W-1:0] res_q;

   logic [7:0]  rx_byte, tx_byte;
   logic [15:0] res_pad;
   logic        meas_ok;

   assign rx_byte = {sh_q[6:0], sda_f};
   assign meas_ok = seen_q & cmd_q.meas;
   assign res_pad = {res_q, {PAD_W{1'b0}}};
   assign tx_byte = !meas_ok ? 8'h00 : (byte_q ? res_pad[7:0] : res_pad[15:8]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         sh_q    <= '0;
         rw_q    <= 1'b0;
         ack_q   <= 1'b0;
         byte_q  <= 1'b0;
         seen_q  <= 1'b0;
         req_q   <= 1'b0;
         cmd_q   <= '0;
         res_q   <= '0;
      end else begin
         if (req_q && conv_done_i) begin
            req_q <= 1'b0;
            res_q <= conv_data_i;
         end
         if (start_det) begin
            state_q <= ST_ADDR;
            bit_q   <= '0;
            ack_q   <= 1'b0;
         end else if (stop_det) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
         end else begin
            unique case (state_q)
               ST_ADDR: if (scl_rise) begin
                  sh_q  <= rx_byte;
                  bit_q <= bit_q + 3'd1;
                  if (bit_q == 3'd7) begin
                     if (rx_byte[7:1] == {ADDR_FIXED, strap_a0_i}) begin
                        rw_q    <= rx_byte[0];
                        byte_q  <= 1'b0;
                        state_q <= ST_ADDR_ACK;
                        if (rx_byte[0] && meas_ok) req_q <= 1'b1;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               ST_ADDR_ACK, ST_CMD_ACK: if (scl_fall) begin
                  if (!ack_q) begin
                     ack_q <= 1'b1;
                  end else begin
                     ack_q <= 1'b0;
                     bit_q <= '0;
                     if (state_q == ST_CMD_ACK) begin
                        state_q <= ST_IDLE;
                     end else if (rw_q) begin
                        sh_q    <= tx_byte;
                        state_q <= ST_TX;
                     end else begin
                        state_q <= ST_CMD;
                     end
                  end
               end
               ST_CMD: if (scl_rise) begin
                  sh_q  <= rx_byte;
                  bit_q <= bit_q + 3'd1;
                  if (bit_q == 3'd7) begin
                     cmd_q   <= '{meas: rx_byte[7], chan: rx_byte[6:4],
                                  pd: rx_byte[2], res8: rx_byte[1]};
                     seen_q  <= 1'b1;
                     state_q <= ST_CMD_ACK;
                  end
               end
               ST_TX: if (scl_fall) begin
                  bit_q <= bit_q + 3'd1;
                  sh_q  <= {sh_q[6:0], 1'b0};
                  if (bit_q == 3'd7) state_q <= ST_TX_ACK;
               end
               ST_TX_ACK: if (scl_rise) begin
                  if (sda_f) begin
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_TX_LOAD;
                     if (!cmd_q.res8 && !byte_q) begin
                        byte_q <= 1'b1;
                     end else begin
                        byte_q <= 1'b0;
                        if (meas_ok) req_q <= 1'b1;
                     end
                  end
               end
               ST_TX_LOAD: if (scl_fall) begin
                  sh_q    <= tx_byte;
                  bit_q   <= '0;
                  state_q <= ST_TX;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o   = ack_q | ((state_q == ST_TX) & ~sh_q[7]);
   assign cmd_meas_o = cmd_q.meas;
   assign cmd_chan_o = cmd_q.chan;
   assign cmd_pd_o   = cmd_q.pd;
   assign cmd_res8_o = cmd_q.res8;
   assign conv_req_o = req_q;

endmodule

// File: rtl/tsc_i2c_target_chk.sv
module tsc_i2c_target_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_f,
   input logic stop_det,
   input logic sda_oe,
   input logic conv_req,
   input logic conv_done,
   input logic cmd_meas
);

   // R10: the data line drive never moves while the filtered clock stays high
   p_oe_stable_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && $past(scl_f)) |-> $stable(sda_oe));

   // R7: a STOP leaves the data line released
   p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R8: request persists until the converter answers
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done) |=> conv_req);

   // R8: request withdrawn once answered
   p_req_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && conv_done) |=> !conv_req);

   // R9: no request without a latched measurement command
   p_req_needs_meas_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_req) |-> cmd_meas);

endmodule

bind tsc_i2c_target tsc_i2c_target_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_f    (scl_f),
   .stop_det (stop_det),
   .sda_oe   (sda_oe_o),
   .conv_req (conv_req_o),
   .conv_done(conv_done_i),
   .cmd_meas (cmd_meas_o)
);

// File: tb/tsc_i2c_target_tb_top.sv
module tsc_i2c_target_tb_top;

   localparam int Q = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
   logic sda_oe, cmd_meas, cmd_pd, cmd_res8, conv_req, conv_done;
   logic [2:0]  cmd_chan;
   logic [11:0] adc_val = 12'h000;
   logic        sda_bus;
   int          n_chk = 0, n_fail = 0, req_rises = 0, dly = 0;
   logic        req_d = 1'b0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   tsc_i2c_target dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .strap_a0_i(strap),
      .cmd_meas_o(cmd_meas), .cmd_chan_o(cmd_chan), .cmd_pd_o(cmd_pd),
      .cmd_res8_o(cmd_res8), .conv_req_o(conv_req),
      .conv_done_i(conv_done), .conv_data_i(adc_val)
   );

   // converter model: answers four clocks after a request
   always @(posedge clk) begin
      if (!rst_n) begin
         conv_done <= 1'b0;
         dly <= 0;
      end else begin
         conv_done <= 1'b0;
         if (conv_req && !conv_done) begin
            if (dly == 3) begin conv_done <= 1'b1; dly <= 0; end
            else dly <= dly + 1;
         end
      end
      req_d <= conv_req;
      if (conv_req && !req_d) req_rises <= req_rises + 1;
   end

   // {cmd, adc value, first byte, second byte, byte count}
   localparam logic [37:0] VEC [5] = '{
      {8'hD0, 12'hA5C, 8'hA5, 8'hC0, 2'd2},
      {8'h96, 12'h3F7, 8'h3F, 8'h00, 2'd1},
      {8'h00, 12'h7FF, 8'h00, 8'h00, 2'd2},
      {8'hE1, 12'h001, 8'h00, 8'h10, 2'd2},
      {8'hFE, 12'hFFF, 8'hFF, 8'h00, 2'd1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic gap;
      repeat (8) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; scl_m = 1'b1; wq(1);
      sda_m = 1'b0; wq(1);
      scl_m = 1'b0; wq(1);
   endtask

   task automatic bus_rstart;
      sda_m = 1'b1; wq(1);
      scl_m = 1'b1; wq(1);
      sda_m = 1'b0; wq(1);
      scl_m = 1'b0; wq(1);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wq(1);
      scl_m = 1'b1; wq(1);
      sda_m = 1'b1; wq(2);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(1);
         scl_m = 1'b1; wq(1);
         if (glitch && i == 4) begin
            scl_m = 1'b0; @(negedge clk); scl_m = 1'b1;
         end
         wq(1);
         scl_m = 1'b0; wq(1);
      end
      sda_m = 1'b1; wq(1);
      scl_m = 1'b1; wq(1);
      ack = !sda_bus;
      wq(1);
      scl_m = 1'b0; wq(1);
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(1);
         scl_m = 1'b1; wq(1);
         b[i] = sda_bus;
         wq(1);
         scl_m = 1'b0;
      end
      gap();
      sda_m = !mack; wq(1);
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; gap();
      sda_m = 1'b1;
   endtask

   task automatic write_cmd(input logic [7:0] addr, input logic [7:0] c, input string tag);
      bit a;
      bus_start();
      send_byte(addr, 1'b0, a); chk({tag, " addr ack"}, a, 1);
      send_byte(c, 1'b0, a);    chk({tag, " cmd ack"}, a, 1);
      bus_stop();
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] b0, b1, b2, b3;
      bit a;
      int r0;
      repeat (5) @(negedge clk);
      // R11: reset state
      chk("R11 sda_oe", sda_oe, 0);
      chk("R11 conv_req", conv_req, 0);
      chk("R11 cmd", {cmd_meas, cmd_chan, cmd_pd, cmd_res8}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R9: read before any command returns zeros, no request
      adc_val = 12'hABC;
      r0 = req_rises;
      bus_start();
      send_byte(8'h91, 1'b0, a); chk("R1 read addr ack", a, 1);
      recv_byte(1'b1, b0); recv_byte(1'b0, b1);
      bus_stop();
      chk("R9 no-cmd bytes", {b0, b1}, 16'h0000);
      chk("R9 no-cmd req", req_rises - r0, 0);

      // table walk: R3 R4 R5 R8 R9
      for (int v = 0; v < 5; v++) begin
         logic [7:0] c;
         c = VEC[v][37:30];
         adc_val = VEC[v][29:18];
         write_cmd(8'h90, c, "R3");
         chk("R3 fields", {cmd_meas, cmd_chan, cmd_pd, cmd_res8},
             {c[7], c[6:4], c[2], c[1]});
         r0 = req_rises;
         bus_start();
         send_byte(8'h91, 1'b0, a); chk("R1 read ack", a, 1);
         if (VEC[v][1:0] == 2'd2) begin
            recv_byte(1'b1, b0); recv_byte(1'b0, b1);
            chk("R4 bytes (R9 when sleep)", {b0, b1}, VEC[v][17:2]);
         end else begin
            recv_byte(1'b0, b0);
            chk("R5 byte", b0, VEC[v][17:10]);
         end
         bus_stop();
         chk("R8 request count", req_rises - r0, c[7] ? 1 : 0);
      end

      // R2: mismatched address, later byte also refused, command unchanged
      bus_start();
      send_byte(8'h92, 1'b0, a); chk("R2 mismatch nack", a, 0);
      send_byte(8'h80, 1'b0, a); chk("R2 ignored byte nack", a, 0);
      bus_stop();
      chk("R2 cmd unchanged", {cmd_meas, cmd_chan, cmd_pd, cmd_res8}, 6'b1_111_1_1);

      // R1: strap high moves the address
      strap = 1'b1;
      write_cmd(8'h92, 8'hA0, "R1 strap");
      chk("R1 strap cmd", {cmd_meas, cmd_chan, cmd_pd, cmd_res8}, 6'b1_010_0_0);

      // R7: command, repeated START, read
      adc_val = 12'h123;
      bus_start();
      send_byte(8'h92, 1'b0, a); chk("R7 addr ack", a, 1);
      send_byte(8'hC0, 1'b0, a); chk("R7 cmd ack", a, 1);
      bus_rstart();
      send_byte(8'h93, 1'b0, a); chk("R7 read ack", a, 1);
      recv_byte(1'b1, b0); recv_byte(1'b0, b1);
      bus_stop();
      chk("R7 bytes", {b0, b1}, 16'h1230);
      chk("R7 sda released", sda_oe, 0);

      // R6: master ACK on last byte streams a second conversion
      adc_val = 12'h5A3;
      r0 = req_rises;
      bus_start();
      send_byte(8'h93, 1'b0, a);
      recv_byte(1'b1, b0);
      adc_val = 12'h6B4;
      recv_byte(1'b1, b1);
      recv_byte(1'b1, b2);
      recv_byte(1'b0, b3);
      bus_stop();
      chk("R6 stream bytes", {b0, b1, b2, b3}, 32'h5A306B40);
      chk("R6 stream requests", req_rises - r0, 2);

      // R10: one-clock SCL dip during an address bit is filtered out
      bus_start();
      send_byte(8'h92, 1'b1, a); chk("R10 glitch ack", a, 1);
      send_byte(8'h82, 1'b0, a); chk("R10 cmd ack", a, 1);
      bus_stop();
      chk("R10 cmd after glitch", {cmd_meas, cmd_chan, cmd_pd, cmd_res8}, 6'b1_000_0_1);

      finish_run();
   end

endmodule